// File: doc/BRIEF.md
# Synchronous Bus Master with Wait-State Insertion

This block sits between a local requester and a shared, clocked memory bus. The requester hands over one word-sized read or write. The master then runs it on the bus as a fixed sequence of three phases: an address phase (T1), a command phase (T2) and a completion phase (T3). The slave can lengthen a transfer by raising a wait line. The master samples that line at the end of T2 and at the end of every inserted wait cycle (Tw). Each high sample adds one Tw cycle before T3.

The bus data lines are bidirectional in concept. Here they are modelled as an output word with an enable plus a separate input word, so a pad ring or an on-chip mux can merge them. After every transfer the strobe drops for at least one cycle. A one-deep request slot takes one new request while a transfer is running. While that slot is occupied, the busy output holds off any further request without losing it.

Top module: `sbus_master`

## Requirements
- R1: While reset is high, and in the first cycle after it, `bus_as`, `bus_doe`, `done` and `req_busy` are low and `rdata` is zero.
- R2: A request is accepted on a rising edge where `req_valid` is high and `req_busy` is low. When the bus is idle, T1 begins in the next cycle. From T1 on, `bus_as` is high, `bus_addr` holds the request address, and `bus_rw` is 1 for a read and 0 for a write.
- R3: With `bus_wait` low, `bus_as` stays high for exactly three cycles (T1, T2, T3). It never stays high for fewer than two cycles after rising.
- R4: Each edge ending T2 or a Tw that samples `bus_wait` high adds exactly one Tw cycle. With N such samples, `done` is high in the cycle that follows the edge N+4 cycles after acceptance.
- R5: For a write, `bus_doe` is high and `bus_dout` equals the write word in every cycle that `bus_as` is high. `bus_doe` is never high outside a write transfer.
- R6: For a read, `rdata` takes `bus_din` as sampled on the edge that ends T3. `rdata` then holds that value until the next read completes; writes leave it unchanged.
- R7: `done` is high for exactly one cycle per transfer, in the cycle after T3.
- R8: In the cycle after T3, `bus_as` and `bus_doe` are low, so consecutive transfers are separated by exactly one idle bus cycle when a request is waiting.
- R9: A request that arrives during a transfer is captured, and `req_busy` is high in the next cycle. While `req_busy` is high, a held request is not taken. Every captured request later runs in arrival order.
- R10: `bus_addr` and `bus_rw` do not change while `bus_as` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Word to write |
| req_busy | output | 1 | Request slot full; a request is not taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last word read from the bus |
| bus_addr | output | AW | Bus address |
| bus_as | output | 1 | Address strobe, high during T1..T3 |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout | output | DW | Data driven toward the slave |
| bus_doe | output | 1 | Enable for `bus_dout` |
| bus_din | input | DW | Data returned by the slave |
| bus_wait | input | 1 | Slave request for one more wait cycle |

## Verification
A slave model in the bench stretches each transfer by a chosen number of wait samples: zero, one, two, three and nine. Comparing strobe length and completion latency across these counts separates the no-wait timing from the per-sample Tw insertion. Writes followed by reads of the same word show whether write data actually reached the slave, and whether read data is taken from the correct edge. A directed sequence offers a second request during a transfer and a third while the slot is full. This checks capture, hold-off, arrival order and the single idle cycle between strobes.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  // Bus phase of the master; T3 is the phase in which data is exchanged.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_TW,
    PH_T3,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/sbus_req_slot.sv
module sbus_req_slot #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          take,
  output logic          full,
  output logic          slot_write,
  output logic [AW-1:0] slot_addr,
  output logic [DW-1:0] slot_wdata
);
  logic accept;
  assign accept = req_valid && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (accept) begin
      full <= 1'b1;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_write <= 1'b0;
      slot_addr  <= '0;
      slot_wdata <= '0;
    end else if (accept) begin
      slot_write <= req_write;
      slot_addr  <= req_addr;
      slot_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/sbus_phase_fsm.sv
module sbus_phase_fsm
  import sbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pending,
  input  logic   bus_wait,
  output phase_t phase,
  output logic   launch,
  output logic   finish
);
  phase_t phase_nx;

  assign launch = pending && ((phase == PH_IDLE) || (phase == PH_GAP));
  assign finish = (phase == PH_T3);

  always_comb begin
    phase_nx = phase;
    case (phase)
      PH_IDLE: phase_nx = launch ? PH_T1 : PH_IDLE;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = bus_wait ? PH_TW : PH_T3;
      PH_TW:   phase_nx = bus_wait ? PH_TW : PH_T3;
      PH_T3:   phase_nx = PH_GAP;
      PH_GAP:  phase_nx = launch ? PH_T1 : PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= phase_nx;
  end
endmodule

// File: rtl/sbus_bus_drive.sv
module sbus_bus_drive #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic          finish,
  input  logic          slot_write,
  input  logic [AW-1:0] slot_addr,
  input  logic [DW-1:0] slot_wdata,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic          bus_as,
  output logic          bus_rw,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  output logic          done,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr <= '0;
      bus_as   <= 1'b0;
      bus_rw   <= 1'b1;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
    end else if (launch) begin
      bus_addr <= slot_addr;
      bus_as   <= 1'b1;
      bus_rw   <= !slot_write;
      bus_dout <= slot_wdata;
      bus_doe  <= slot_write;
    end else if (finish) begin
      bus_as   <= 1'b0;
      bus_doe  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= finish;
      if (finish && bus_rw) rdata <= bus_din;
    end
  end
endmodule

// File: rtl/sbus_master.sv
module sbus_master #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_as,
  output logic          bus_rw,
  output logic [DW-1:0] bus_dout,
  output logic          bus_doe,
  input  logic [DW-1:0] bus_din,
  input  logic          bus_wait
);
  import sbus_pkg::*;

  logic          full;
  logic          launch;
  logic          finish;
  logic          slot_write;
  logic [AW-1:0] slot_addr;
  logic [DW-1:0] slot_wdata;
  phase_t        phase;

  sbus_req_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .take       (launch),
    .full       (full),
    .slot_write (slot_write),
    .slot_addr  (slot_addr),
    .slot_wdata (slot_wdata)
  );

  sbus_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pending  (full),
    .bus_wait (bus_wait),
    .phase    (phase),
    .launch   (launch),
    .finish   (finish)
  );

  sbus_bus_drive #(.AW(AW), .DW(DW)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .finish     (finish),
    .slot_write (slot_write),
    .slot_addr  (slot_addr),
    .slot_wdata (slot_wdata),
    .bus_din    (bus_din),
    .bus_addr   (bus_addr),
    .bus_as     (bus_as),
    .bus_rw     (bus_rw),
    .bus_dout   (bus_dout),
    .bus_doe    (bus_doe),
    .done       (done),
    .rdata      (rdata)
  );

  assign req_busy = full;
endmodule

// File: rtl/sbus_master_chk.sv
module sbus_master_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic          bus_as,
  input logic          bus_rw,
  input logic          bus_doe,
  input logic          bus_wait
);
  logic as_q;
  logic in_t3;

  // Tracks whether the strobe was high last cycle and whether T3 has been reached.
  always_ff @(posedge clk) begin
    if (rst) begin
      as_q  <= 1'b0;
      in_t3 <= 1'b0;
    end else begin
      as_q <= bus_as;
      if (!bus_as)                in_t3 <= 1'b0;
      else if (as_q && !bus_wait) in_t3 <= 1'b1;
    end
  end

  assert_min_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_as) |=> bus_as);

  assert_wait_stretch_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_as && as_q && !in_t3 && bus_wait) |=> (bus_as && !done));

  assert_drive_write_only_R5: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (bus_as && !bus_rw));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_after_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_as && !bus_doe));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_as && as_q) |-> ($stable(bus_addr) && $stable(bus_rw)));
endmodule

bind sbus_master sbus_master_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sbus_master_bench.sv
module sbus_master_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 9;
  localparam int VW = 1 + AW + DW + 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_busy, done, bus_as, bus_rw, bus_doe, bus_wait;
  logic [DW-1:0] rdata, bus_dout, bus_din;
  logic [AW-1:0] bus_addr;

  always #4 clk = !clk;

  sbus_master #(.AW(AW), .DW(DW)) u_sbus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_busy(req_busy),
    .done(done), .rdata(rdata), .bus_addr(bus_addr), .bus_as(bus_as),
    .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din), .bus_wait(bus_wait)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Slave model: 16-word memory, wait line driven for nwait_cfg samples.
  logic [DW-1:0] mem [16];
  logic [DW-1:0] ref_mem [16];
  int cyc;
  int nwait_cfg = 0;

  assign bus_wait = bus_as && (cyc >= 1) && (cyc <= nwait_cfg);
  assign bus_din  = mem[bus_addr[3:0]];

  always @(posedge clk) begin
    if (rst) begin
      cyc <= 0;
      for (int j = 0; j < 16; j++) mem[j] <= 32'hC0DE_0000 + j * 32'h111;
    end else begin
      cyc <= bus_as ? cyc + 1 : 0;
      if (bus_as && !bus_rw && cyc >= 1 && !bus_wait) mem[bus_addr[3:0]] <= bus_dout;
    end
  end

  // Monitor for the overlapped-request sequence.
  int mon_done = 0, mon_nas = 0, gap_run = 0, min_gap = 99;
  logic as_prev = 1'b0;
  logic [DW-1:0] mon_rd [4];
  logic [AW-1:0] mon_addr [4];
  always @(negedge clk) begin
    if (done && mon_done < 4) begin mon_rd[mon_done] = rdata; mon_done++; end
    if (bus_as && !as_prev && mon_nas < 4) begin
      mon_addr[mon_nas] = bus_addr;
      mon_nas++;
      if (mon_nas > 1 && gap_run < min_gap) min_gap = gap_run;
    end
    gap_run = bus_as ? 0 : gap_run + 1;
    as_prev = bus_as;
  end

  // Watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 20000", wd);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Vectors: {write, addr, wdata, nwait}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 16'h0002, 32'h0000_0000, 4'd0},
    {1'b1, 16'h0002, 32'hDEAD_BEEF, 4'd0},
    {1'b0, 16'h0002, 32'h0000_0000, 4'd0},
    {1'b0, 16'h0007, 32'h0000_0000, 4'd1},
    {1'b1, 16'h0009, 32'h1234_5678, 4'd3},
    {1'b0, 16'h0009, 32'h0000_0000, 4'd2},
    {1'b0, 16'h000F, 32'h0000_0000, 4'd9},
    {1'b1, 16'h0000, 32'hFFFF_0001, 4'd1},
    {1'b0, 16'h0000, 32'h0000_0000, 4'd0}
  };

  logic [DW-1:0] last_rd = '0;

  task automatic run_xfer(input logic w, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int nw);
    int lat = 0, ascyc = 0, first_as = -1;
    bit addr_ok = 1, drv_ok = 1;
    logic [DW-1:0] exp_rd;
    nwait_cfg = nw;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && lat < 100) begin
      if (bus_as) begin
        if (first_as < 0) first_as = lat;
        ascyc++;
        if (bus_addr != a || bus_rw != !w) addr_ok = 0;
        if (w ? (!bus_doe || bus_dout != d) : bus_doe) drv_ok = 0;
      end
      @(negedge clk);
      lat++;
    end
    check(first_as == 1, "R2 start cycle", first_as, 1);
    check(addr_ok, "R2 R10 address and direction", bus_addr, a);
    check(lat == 4 + nw, nw == 0 ? "R3 latency" : "R4 latency", lat, 4 + nw);
    check(ascyc == 3 + nw, "R3 R4 strobe length", ascyc, 3 + nw);
    check(drv_ok, "R5 data drive", bus_doe, w);
    check(!bus_as && !bus_doe, "R8 idle after T3", bus_as, 0);
    if (w) begin
      ref_mem[a[3:0]] = d;
      exp_rd = last_rd;
    end else begin
      exp_rd = ref_mem[a[3:0]];
      last_rd = exp_rd;
    end
    check(rdata == exp_rd, "R6 read word", rdata, exp_rd);
    @(negedge clk);
    check(!done, "R7 single pulse", done, 0);
    check(rdata == exp_rd, "R6 hold", rdata, exp_rd);
  endtask

  initial begin
    for (int j = 0; j < 16; j++) ref_mem[j] = 32'hC0DE_0000 + j * 32'h111;
    repeat (3) @(negedge clk);
    check(!bus_as && !bus_doe && !done && !req_busy, "R1 during reset", bus_as, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_as && !bus_doe && !done && !req_busy && rdata == 0, "R1 after reset",
          rdata, 0);

    for (int i = 0; i < NV; i++) begin
      run_xfer(VEC[i][VW-1], VEC[i][VW-2 -: AW], VEC[i][DW+3 -: DW],
               int'(VEC[i][3:0]));
    end

    // Overlapped requests: A running, B captured, C held while busy (R9, R8).
    mon_done = 0; mon_nas = 0; min_gap = 99;
    nwait_cfg = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0003;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 32'hA5A5_0F0F;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_busy, "R9 busy after capture", req_busy, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0005;
    @(negedge clk);
    check(req_busy && bus_as && bus_addr == 16'h0003, "R9 held while busy",
          bus_addr, 16'h0003);
    for (int k = 0; k < 100 && req_busy; k++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 200 && mon_done < 3; k++) @(negedge clk);
    check(mon_done == 3, "R9 all three complete", mon_done, 3);
    check(mon_addr[0] == 16'h0003 && mon_addr[1] == 16'h0005 && mon_addr[2] == 16'h0005,
          "R9 arrival order", mon_addr[1], 16'h0005);
    check(mon_rd[0] == ref_mem[3], "R6 first read", mon_rd[0], ref_mem[3]);
    check(mon_rd[2] == 32'hA5A5_0F0F, "R9 write reached slave", mon_rd[2], 32'hA5A5_0F0F);
    check(min_gap == 1, "R8 single idle cycle", min_gap, 1);
    check(!req_busy && !bus_as, "R9 drained", req_busy, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule